// File: doc/BRIEF.md
# Processor Hotplug Slot Register Controller

This block keeps the hot-add and hot-remove bookkeeping for a fixed set of processor slots and exposes it to software through a small register window of 12 bytes, addressed in bytes and read and written little-endian with accesses of one, two or four bytes. Software points a selector at one slot. It then reads that slot's packed presence and event flags, acknowledges events, asks for the slot to be ejected, and issues commands. One command searches the slots circularly for the next pending event and moves the selector there. Another exposes the slot's 64-bit identifier as two 32-bit halves. Two further commands let software deposit a per-slot status event code and a status code; the second of these is reported outward as a one-cycle pulse.

On the hardware side, plug, unplug-request and unplug-complete inputs mark slots present, raise insert or remove events and clear presence. A level interrupt stays high while any slot has an event outstanding. Eject requests leave the block as a one-cycle pulse with the slot index, for an external power sequencer.

The active command is the block's state machine, encoded by the type `hp_cmd_e`. The states are CMD_SCAN (code 0, the reset state), CMD_EVCODE (code 1), CMD_STCODE (code 2) and CMD_GETID (code 3). Every state moves to every other state, or back to itself, on an in-range command write whose masked value is 0 to 3. A command write with a value of 4 or more keeps the current state, and so does a command write made while the selector is out of range. Reset returns the machine to CMD_SCAN.

Top module: `hpslot_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the selector to 0, the command to CMD_SCAN, all insert and remove events and event codes to 0, and every output to 0. Reset loads each slot's present bit from `pres_init_i`.
- R2: Each access is decoded by its starting byte address alone. `bus_size_i` encodes the width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. Write data is masked to that width. Read data appears on `bus_rdata_o` in the cycle after `bus_rd_i`, masked to the width, and holds until the next read. A read while `bus_wr_i` is high is ignored. Addresses other than 0, 4, 5 and 8 read as zero, and writes to them are ignored.
- R3: A read at address 4 returns bit 0 = slot present, bit 1 = insert event pending and bit 2 = remove event pending for the selected slot, with the other bits zero.
- R4: A write at address 4 is decoded by priority. If bit 1 is set, it clears only the insert event. Otherwise, if bit 2 is set, it clears only the remove event. Otherwise, if bit 3 is set, it requests ejection.
- R5: An eject request on a present slot other than slot 0 drives `ej_pulse_o` high for one cycle, with `ej_slot_o` holding the slot, in the cycle after the write. Requests on slot 0 or on an absent slot produce no pulse. `ej_slot_o` is 0 when there is no pulse.
- R6: A write at address 5 with value 0 to 3 selects that command. A value of 4 or more leaves the command unchanged.
- R7: Writing command 0 scans the slots from the selector upward, wrapping from the last slot to 0, and loads the selector with the first slot that has an insert or remove event. If no slot has one, the selector is unchanged. Under command 0, address 8 reads the selector and address 0 reads zero.
- R8: Under command 3, address 8 reads bits 31:0 and address 0 reads bits 63:32 of the selected slot's identifier from `slot_id_i` (slot k occupies bits 64k+63:64k).
- R9: While the selector is N_SLOTS or more, every read returns zero and every write except a selector write at address 0 is dropped.
- R10: Under command 1, a write at address 8 stores the slot's 32-bit event code. Under command 2, a write at address 8 drives `sts_pulse_o` for one cycle in the following cycle. The pulse carries the slot, the slot's stored event code and the written status code. The pulse fields are zero when there is no pulse. Under commands 1 and 2, addresses 0 and 8 read zero.
- R11: `plug_i` sets the present bit of its slot, and when `plug_hot_i` is also high it sets the insert event. `unreq_i` sets the remove event. `undone_i` clears presence. A hardware set wins over a software clear of the same flag in the same cycle, and a plug wins over an unplug-complete on the same slot.
- R12: `irq_o` is high exactly while at least one slot has an insert or remove event pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pres_init_i | input | N_SLOTS | Present bits loaded at reset |
| slot_id_i | input | 64*N_SLOTS | Per-slot 64-bit identifiers |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 4 | Starting byte address |
| bus_size_i | input | 2 | Access width code |
| bus_wdata_i | input | 32 | Write data, little-endian, aligned to bit 0 |
| bus_rdata_o | output | 32 | Registered read data |
| plug_i | input | 1 | Slot plugged |
| plug_hot_i | input | 1 | The plug is a hot-add |
| plug_slot_i | input | SW | Slot of the plug |
| unreq_i | input | 1 | Unplug request |
| unreq_slot_i | input | SW | Slot of the unplug request |
| undone_i | input | 1 | Unplug complete |
| undone_slot_i | input | SW | Slot of the unplug completion |
| irq_o | output | 1 | Event interrupt level |
| ej_pulse_o | output | 1 | Eject pulse |
| ej_slot_o | output | SW | Slot to eject |
| sts_pulse_o | output | 1 | Status report pulse |
| sts_slot_o | output | SW | Slot of the status report |
| sts_event_o | output | 32 | Stored event code of that slot |
| sts_code_o | output | 32 | Status code written |

## Verification
The bench goes after the circular scan. It starts the scan from slots above, below and on the pending one, so that it must wrap past the last slot, and it also runs the scan with no event pending. A design that searched only upward, or started one past the selector, would land on the wrong slot or zero the selector. It exercises the flag-write priority with several bits set at once, ejects aimed at slot 0 and at an absent slot, command values of 4 and above, and a selector beyond the last slot. An inverted priority, a missing boot-slot guard, a command overwritten by an illegal code, or a dropped range check would each show up as a wrong flag, an unexpected pulse or non-zero read data. It also drives a hardware event into the same cycle as a software clear of that flag and checks that the event survives.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;

    typedef enum logic [1:0] {
        CMD_SCAN   = 2'd0,
        CMD_EVCODE = 2'd1,
        CMD_STCODE = 2'd2,
        CMD_GETID  = 2'd3
    } hp_cmd_e;

    localparam logic [3:0] OFF_SEL_HI = 4'd0;
    localparam logic [3:0] OFF_FLAGS  = 4'd4;
    localparam logic [3:0] OFF_CMD    = 4'd5;
    localparam logic [3:0] OFF_DATA   = 4'd8;

    localparam int FLG_PRES = 0;
    localparam int FLG_INS  = 1;
    localparam int FLG_RMV  = 2;
    localparam int FLG_EJ   = 3;

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/hpslot_slot.sv
module hpslot_slot (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pres_init_i,
    input  logic        plug_i,
    input  logic        hot_i,
    input  logic        undone_i,
    input  logic        unreq_i,
    input  logic        clr_ins_i,
    input  logic        clr_rmv_i,
    input  logic        wr_code_i,
    input  logic [31:0] code_i,
    output logic        pres_o,
    output logic        ins_o,
    output logic        rmv_o,
    output logic [31:0] code_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_o <= pres_init_i;
            ins_o  <= 1'b0;
            rmv_o  <= 1'b0;
            code_o <= '0;
        end else begin
            // presence: plug beats unplug-complete
            if (plug_i)
                pres_o <= 1'b1;
            else if (undone_i)
                pres_o <= 1'b0;
            // hardware set beats software clear
            if (plug_i && hot_i)
                ins_o <= 1'b1;
            else if (clr_ins_i)
                ins_o <= 1'b0;
            if (unreq_i)
                rmv_o <= 1'b1;
            else if (clr_rmv_i)
                rmv_o <= 1'b0;
            if (wr_code_i)
                code_o <= code_i;
        end
    end

    // R11: a plug always leaves the slot present
    a_r11_plug_present: assert property (@(posedge clk) disable iff (!rst_n)
        plug_i |=> pres_o);

    // R11: a hot-add survives a same-cycle software clear
    a_r11_hot_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_i && hot_i) |=> ins_o);

    // R4: an uncontested clear removes the insert event
    a_r4_clear_ins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ins_i && !(plug_i && hot_i)) |=> !ins_o);

endmodule

// File: rtl/hpslot_scan.sv
module hpslot_scan #(
    parameter int N_SLOTS = 8,
    localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic [N_SLOTS-1:0] pend_i,
    input  logic [SW-1:0]      start_i,
    output logic               found_o,
    output logic [SW-1:0]      idx_o
);

    localparam logic [SW:0] N_W = (SW+1)'(N_SLOTS);

    logic [SW:0] pos;

    // walk the distances from far to near so the nearest pending slot wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = start_i;
        pos     = '0;
        for (int k = N_SLOTS - 1; k >= 0; k--) begin
            pos = {1'b0, start_i} + (SW+1)'(k);
            if (pos >= N_W)
                pos = pos - N_W;
            if (pend_i[pos[SW-1:0]]) begin
                found_o = 1'b1;
                idx_o   = pos[SW-1:0];
            end
        end
    end

endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
    import hpslot_pkg::*;
#(
    parameter int N_SLOTS = 8,
    localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SLOTS-1:0]     pres_init_i,
    input  logic [64*N_SLOTS-1:0]  slot_id_i,
    input  logic                   bus_rd_i,
    input  logic                   bus_wr_i,
    input  logic [3:0]             bus_addr_i,
    input  logic [1:0]             bus_size_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            bus_rdata_o,
    input  logic                   plug_i,
    input  logic                   plug_hot_i,
    input  logic [SW-1:0]          plug_slot_i,
    input  logic                   unreq_i,
    input  logic [SW-1:0]          unreq_slot_i,
    input  logic                   undone_i,
    input  logic [SW-1:0]          undone_slot_i,
    output logic                   irq_o,
    output logic                   ej_pulse_o,
    output logic [SW-1:0]          ej_slot_o,
    output logic                   sts_pulse_o,
    output logic [SW-1:0]          sts_slot_o,
    output logic [31:0]            sts_event_o,
    output logic [31:0]            sts_code_o
);

    localparam int          IDW   = 64;
    localparam logic [31:0] N_LIM = 32'(N_SLOTS);

    // state and selector
    hp_cmd_e     cmd_q, cmd_d;
    logic [31:0] sel_q;

    // bus decode
    logic [31:0] wmask, wdat;
    logic        sel_ok, wr_ok, rd_go;
    logic [SW-1:0] sel_idx;
    logic        hit_sel, hit_flags, hit_cmd, hit_data;
    logic        fw, clr_ins, clr_rmv, ej_req, ej_go;
    logic        cw, scan_go, dw, evc_go, sts_go;

    // per-slot vectors
    logic [N_SLOTS-1:0] pres_v, ins_v, rmv_v, pend_v, sel_oh;
    logic [31:0]        ev_code [N_SLOTS];

    logic          scan_found;
    logic [SW-1:0] scan_idx;
    logic [31:0]   id_lo, id_hi, rd_val;

    assign wmask   = size_mask(bus_size_i);
    assign wdat    = bus_wdata_i & wmask;
    assign sel_ok  = (sel_q < N_LIM);
    assign sel_idx = sel_q[SW-1:0];
    assign wr_ok   = bus_wr_i && sel_ok;
    assign rd_go   = bus_rd_i && !bus_wr_i;

    assign hit_sel   = (bus_addr_i == OFF_SEL_HI);
    assign hit_flags = (bus_addr_i == OFF_FLAGS);
    assign hit_cmd   = (bus_addr_i == OFF_CMD);
    assign hit_data  = (bus_addr_i == OFF_DATA);

    // flags write with its priority order
    assign fw      = wr_ok && hit_flags;
    assign clr_ins = fw && wdat[FLG_INS];
    assign clr_rmv = fw && !wdat[FLG_INS] && wdat[FLG_RMV];
    assign ej_req  = fw && !wdat[FLG_INS] && !wdat[FLG_RMV] && wdat[FLG_EJ];
    assign ej_go   = ej_req && pres_v[sel_idx] && (sel_idx != '0);

    assign cw      = wr_ok && hit_cmd;
    assign scan_go = cw && (wdat == 32'd0);
    assign dw      = wr_ok && hit_data;
    assign evc_go  = dw && (cmd_q == CMD_EVCODE);
    assign sts_go  = dw && (cmd_q == CMD_STCODE);

    assign pend_v = ins_v | rmv_v;
    assign irq_o  = |pend_v;

    // ---------------- slot array ----------------
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        assign sel_oh[i] = sel_ok && (sel_idx == SW'(i));

        hpslot_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .pres_init_i(pres_init_i[i]),
            .plug_i     (plug_i && (plug_slot_i == SW'(i))),
            .hot_i      (plug_hot_i),
            .undone_i   (undone_i && (undone_slot_i == SW'(i))),
            .unreq_i    (unreq_i && (unreq_slot_i == SW'(i))),
            .clr_ins_i  (clr_ins && sel_oh[i]),
            .clr_rmv_i  (clr_rmv && sel_oh[i]),
            .wr_code_i  (evc_go && sel_oh[i]),
            .code_i     (wdat),
            .pres_o     (pres_v[i]),
            .ins_o      (ins_v[i]),
            .rmv_o      (rmv_v[i]),
            .code_o     (ev_code[i])
        );
    end

    hpslot_scan #(.N_SLOTS(N_SLOTS)) u_scan (
        .pend_i (pend_v),
        .start_i(sel_idx),
        .found_o(scan_found),
        .idx_o  (scan_idx)
    );

    // ---------------- command state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= CMD_SCAN;
        else
            cmd_q <= cmd_d;
    end

    always_comb begin
        cmd_d = cmd_q;
        if (cw) begin
            unique case (wdat)
                32'd0:   cmd_d = CMD_SCAN;
                32'd1:   cmd_d = CMD_EVCODE;
                32'd2:   cmd_d = CMD_STCODE;
                32'd3:   cmd_d = CMD_GETID;
                default: cmd_d = cmd_q;
            endcase
        end
    end

    // selector: direct write, or landing point of a scan
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr_i && hit_sel)
            sel_q <= wdat;
        else if (scan_go && scan_found)
            sel_q <= 32'(scan_idx);
    end

    // ---------------- read mux and output registers ----------------
    assign id_lo = slot_id_i[int'(sel_idx)*IDW +: 32];
    assign id_hi = slot_id_i[int'(sel_idx)*IDW + 32 +: 32];

    always_comb begin
        rd_val = '0;
        if (sel_ok) begin
            if (hit_flags) begin
                rd_val[FLG_PRES] = pres_v[sel_idx];
                rd_val[FLG_INS]  = ins_v[sel_idx];
                rd_val[FLG_RMV]  = rmv_v[sel_idx];
            end else if (hit_data) begin
                unique case (cmd_q)
                    CMD_SCAN:   rd_val = sel_q;
                    CMD_GETID:  rd_val = id_lo;
                    CMD_EVCODE,
                    CMD_STCODE: rd_val = '0;
                endcase
            end else if (hit_sel) begin
                unique case (cmd_q)
                    CMD_GETID:  rd_val = id_hi;
                    CMD_SCAN,
                    CMD_EVCODE,
                    CMD_STCODE: rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
            ej_pulse_o  <= 1'b0;
            ej_slot_o   <= '0;
            sts_pulse_o <= 1'b0;
            sts_slot_o  <= '0;
            sts_event_o <= '0;
            sts_code_o  <= '0;
        end else begin
            if (rd_go)
                bus_rdata_o <= rd_val & wmask;
            ej_pulse_o  <= ej_go;
            ej_slot_o   <= ej_go ? sel_idx : '0;
            sts_pulse_o <= sts_go;
            sts_slot_o  <= sts_go ? sel_idx : '0;
            sts_event_o <= sts_go ? ev_code[sel_idx] : '0;
            sts_code_o  <= sts_go ? wdat : '0;
        end
    end

    // ---------------- assertions ----------------
    // R6: an illegal command code leaves the state alone
    a_r6_bad_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && hit_cmd && (wdat >= 32'd4)) |=> $stable(cmd_q));

    // R7: a scan with any event pending lands on a slot with an event
    a_r7_scan_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_go && (|pend_v)) |=> (ins_v[sel_idx] || rmv_v[sel_idx]));

    // R9: reads with the selector out of range return zero
    a_r9_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !sel_ok) |=> (bus_rdata_o == 32'd0));

    // R5: the boot slot is never ejected
    a_r5_no_boot_eject: assert property (@(posedge clk) disable iff (!rst_n)
        ej_pulse_o |-> (ej_slot_o != '0));

    // R12: the interrupt only rises after a hardware event input
    a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((plug_i && plug_hot_i) || unreq_i));

    // R10: a status report follows a data write under command 2
    a_r10_sts_from_cmd2: assert property (@(posedge clk) disable iff (!rst_n)
        sts_pulse_o |-> $past(cmd_q == CMD_STCODE));

endmodule

// File: tb/hpslot_ctrl_bench.sv
`timescale 1ns/1ps
module hpslot_ctrl_bench;

    localparam int N  = 8;
    localparam int SW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      pres_init = 8'b0000_0111;
    logic [64*N-1:0]   slot_id;
    logic              bus_rd = 0, bus_wr = 0;
    logic [3:0]        bus_addr = 0;
    logic [1:0]        bus_size = 0;
    logic [31:0]       bus_wdata = 0;
    logic [31:0]       bus_rdata;
    logic              plug = 0, plug_hot = 0, unreq = 0, undone = 0;
    logic [SW-1:0]     plug_slot = 0, unreq_slot = 0, undone_slot = 0;
    logic              irq, ej_pulse, sts_pulse;
    logic [SW-1:0]     ej_slot, sts_slot;
    logic [31:0]       sts_event, sts_code;

    always #10 clk = ~clk;

    hpslot_ctrl #(.N_SLOTS(N)) u_hpslot_ctrl (
        .clk(clk), .rst_n(rst_n), .pres_init_i(pres_init), .slot_id_i(slot_id),
        .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_size_i(bus_size), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .plug_i(plug), .plug_hot_i(plug_hot), .plug_slot_i(plug_slot),
        .unreq_i(unreq), .unreq_slot_i(unreq_slot),
        .undone_i(undone), .undone_slot_i(undone_slot),
        .irq_o(irq), .ej_pulse_o(ej_pulse), .ej_slot_o(ej_slot),
        .sts_pulse_o(sts_pulse), .sts_slot_o(sts_slot),
        .sts_event_o(sts_event), .sts_code_o(sts_code)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int unsigned m_sel;
    int          m_cmd;
    bit          m_pres [N];
    bit          m_ins  [N];
    bit          m_rmv  [N];
    logic [31:0] m_ev   [N];

    // expected outputs after the next edge
    logic [31:0] e_rdata, e_sev, e_scode;
    bit          e_irq, e_ej, e_sp;
    int          e_ejs, e_ss;
    string       e_rtag;

    // stimulus for the next edge
    bit          s_rd, s_wr, s_plug, s_hot, s_unreq, s_undone;
    logic [3:0]  s_addr;
    logic [1:0]  s_size;
    logic [31:0] s_wdata;
    int          s_pslot, s_uslot, s_dslot;

    function automatic logic [63:0] id_of(int i);
        id_of = {32'hC0DE_0000 + 32'(i) * 32'h0101, 32'h1000_0000 + 32'(i) * 32'h0003_0005};
    endfunction

    function automatic logic [31:0] msk(logic [1:0] sz);
        if (sz == 2'd0) msk = 32'hFF;
        else if (sz == 2'd1) msk = 32'hFFFF;
        else msk = 32'hFFFF_FFFF;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic stim_idle();
        s_rd = 0; s_wr = 0; s_addr = 0; s_size = 0; s_wdata = 0;
        s_plug = 0; s_hot = 0; s_unreq = 0; s_undone = 0;
        s_pslot = 0; s_uslot = 0; s_dslot = 0;
    endtask

    task automatic model_step();
        logic [31:0] wd, v;
        bit ok, hit;
        int si, new_sel;
        wd = s_wdata & msk(s_size);
        ok = (m_sel < N);
        si = ok ? int'(m_sel) : 0;
        new_sel = int'(m_sel);
        e_ej = 0; e_ejs = 0; e_sp = 0; e_ss = 0; e_sev = 0; e_scode = 0;
        if (s_rd && !s_wr) begin
            v = 0;
            if (!ok) e_rtag = "R9";
            else if (s_addr == 4) begin
                v = {29'd0, m_rmv[si], m_ins[si], m_pres[si]}; e_rtag = "R3";
            end else if (s_addr == 8) begin
                if (m_cmd == 0) begin v = m_sel; e_rtag = "R7"; end
                else if (m_cmd == 3) begin v = id_of(si)[31:0]; e_rtag = "R8"; end
                else e_rtag = "R10";
            end else if (s_addr == 0) begin
                if (m_cmd == 3) begin v = id_of(si)[63:32]; e_rtag = "R8"; end
                else if (m_cmd == 0) e_rtag = "R7";
                else e_rtag = "R10";
            end else e_rtag = "R2";
            e_rdata = v & msk(s_size);
        end
        if (s_wr) begin
            if (s_addr == 0) new_sel = int'(wd);
            else if (s_addr == 4 && ok) begin
                if (wd[1]) m_ins[si] = 0;
                else if (wd[2]) m_rmv[si] = 0;
                else if (wd[3] && m_pres[si] && si != 0) begin e_ej = 1; e_ejs = si; end
            end else if (s_addr == 5 && ok && wd < 4) begin
                m_cmd = int'(wd);
                if (wd == 0) begin
                    hit = 0;
                    for (int k = 0; k < N; k++) begin
                        if (!hit && (m_ins[(si + k) % N] || m_rmv[(si + k) % N])) begin
                            hit = 1; new_sel = (si + k) % N;
                        end
                    end
                end
            end else if (s_addr == 8 && ok) begin
                if (m_cmd == 1) m_ev[si] = wd;
                else if (m_cmd == 2) begin
                    e_sp = 1; e_ss = si; e_sev = m_ev[si]; e_scode = wd;
                end
            end
        end
        if (s_undone) m_pres[s_dslot] = 0;
        if (s_plug) begin
            m_pres[s_pslot] = 1;
            if (s_hot) m_ins[s_pslot] = 1;
        end
        if (s_unreq) m_rmv[s_uslot] = 1;
        m_sel = new_sel;
        e_irq = 0;
        for (int i = 0; i < N; i++) if (m_ins[i] || m_rmv[i]) e_irq = 1;
    endtask

    // compare last edge, step the model, apply the next stimulus
    task automatic tick();
        @(negedge clk);
        chk({e_rtag, " rdata"}, bus_rdata, e_rdata);
        chk("R12 irq", 32'(irq), 32'(e_irq));
        chk("R5 ej_pulse", 32'(ej_pulse), 32'(e_ej));
        chk("R5 ej_slot", 32'(ej_slot), 32'(e_ejs));
        chk("R10 sts_pulse", 32'(sts_pulse), 32'(e_sp));
        chk("R10 sts_slot", 32'(sts_slot), 32'(e_ss));
        chk("R10 sts_event", sts_event, e_sev);
        chk("R10 sts_code", sts_code, e_scode);
        model_step();
        bus_rd = s_rd; bus_wr = s_wr; bus_addr = s_addr; bus_size = s_size;
        bus_wdata = s_wdata; plug = s_plug; plug_hot = s_hot; plug_slot = SW'(s_pslot);
        unreq = s_unreq; unreq_slot = SW'(s_uslot); undone = s_undone;
        undone_slot = SW'(s_dslot);
        stim_idle();
    endtask

    task automatic wr(logic [3:0] a, logic [1:0] sz, logic [31:0] d);
        s_wr = 1; s_addr = a; s_size = sz; s_wdata = d; tick();
    endtask

    task automatic rd(logic [3:0] a, logic [1:0] sz);
        s_rd = 1; s_addr = a; s_size = sz; tick();
    endtask

    initial begin
        for (int i = 0; i < N; i++) slot_id[i*64 +: 64] = id_of(i);
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        stim_idle();
        repeat (4) @(negedge clk);
        rst_n = 1;
        m_sel = 0; m_cmd = 0;
        for (int i = 0; i < N; i++) begin
            m_pres[i] = pres_init[i]; m_ins[i] = 0; m_rmv[i] = 0; m_ev[i] = 0;
        end
        e_rdata = 0; e_irq = 0; e_ej = 0; e_ejs = 0; e_sp = 0; e_ss = 0;
        e_sev = 0; e_scode = 0; e_rtag = "R1";
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 rdata after reset", bus_rdata, 32'd0);
        // R1/R3: slot 0 present from the init vector, no events
        rd(4'd4, 2'd0);
        // R11/R12: hot-add slot 5, remove request on slot 2
        s_plug = 1; s_hot = 1; s_pslot = 5; tick();
        s_unreq = 1; s_uslot = 2; tick();
        wr(4'd0, 2'd2, 32'd5); rd(4'd4, 2'd0);
        // R7: scan from 3 finds 5; from 6 wraps to 2; from 2 stays on 2
        wr(4'd0, 2'd2, 32'd3); wr(4'd5, 2'd0, 32'd0); rd(4'd8, 2'd2); rd(4'd0, 2'd2);
        wr(4'd0, 2'd2, 32'd6); wr(4'd5, 2'd0, 32'd0); rd(4'd8, 2'd2);
        wr(4'd5, 2'd0, 32'd0); rd(4'd8, 2'd2);
        // R4: bits 1 and 2 together on slot 2 clear only insert (none), remove stays
        wr(4'd4, 2'd0, 32'h6); rd(4'd4, 2'd0);
        wr(4'd4, 2'd0, 32'h4); rd(4'd4, 2'd0);
        // R4: bit 3 with bit 1 does not eject
        wr(4'd0, 2'd2, 32'd5); wr(4'd4, 2'd0, 32'hA); rd(4'd4, 2'd0);
        // R5: eject present slot 1, boot slot 0, absent slot 7
        wr(4'd0, 2'd2, 32'd1); wr(4'd4, 2'd0, 32'h8);
        wr(4'd0, 2'd2, 32'd0); wr(4'd4, 2'd0, 32'h8);
        wr(4'd0, 2'd2, 32'd7); wr(4'd4, 2'd0, 32'h8);
        // R8/R2: identifier halves at several widths
        wr(4'd0, 2'd2, 32'd4); wr(4'd5, 2'd0, 32'd3);
        rd(4'd8, 2'd2); rd(4'd0, 2'd2); rd(4'd8, 2'd0); rd(4'd0, 2'd1);
        rd(4'd1, 2'd2); rd(4'd12, 2'd2);
        // R6: illegal command codes keep command 3
        wr(4'd5, 2'd0, 32'd9); rd(4'd8, 2'd2);
        wr(4'd5, 2'd2, 32'h0000_0104); rd(4'd0, 2'd2);
        // R10: event code then status report
        wr(4'd5, 2'd0, 32'd1); wr(4'd8, 2'd2, 32'hDEAD_1234); rd(4'd8, 2'd2);
        wr(4'd5, 2'd0, 32'd2); wr(4'd8, 2'd1, 32'hFFFF_0080); rd(4'd0, 2'd2);
        // R9: selector out of range
        wr(4'd0, 2'd2, 32'd5); wr(4'd5, 2'd0, 32'd0);
        wr(4'd0, 2'd2, 32'd20); rd(4'd4, 2'd0); rd(4'd8, 2'd2);
        wr(4'd4, 2'd0, 32'h2); wr(4'd5, 2'd0, 32'd3);
        wr(4'd0, 2'd2, 32'd5); rd(4'd4, 2'd0); rd(4'd8, 2'd2);
        // R7: clear all events, scan with nothing pending keeps selector
        wr(4'd4, 2'd0, 32'h2); wr(4'd0, 2'd2, 32'd2); wr(4'd4, 2'd0, 32'h4);
        wr(4'd0, 2'd2, 32'd6); wr(4'd5, 2'd0, 32'd0); rd(4'd8, 2'd2);
        // R11: hardware set against software clear in one cycle
        s_plug = 1; s_hot = 1; s_pslot = 6; wr(4'd4, 2'd0, 32'h2); rd(4'd4, 2'd0);
        s_unreq = 1; s_uslot = 6; wr(4'd4, 2'd0, 32'h4); rd(4'd4, 2'd0);
        // R11: plug beats unplug-complete; unplug-complete alone clears presence
        s_plug = 1; s_pslot = 3; s_undone = 1; s_dslot = 3; tick();
        wr(4'd0, 2'd2, 32'd3); rd(4'd4, 2'd0);
        s_undone = 1; s_dslot = 3; tick(); rd(4'd4, 2'd0);
        // random traffic, all requirements against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            s_size = 2'($urandom_range(0, 3));
            case (r)
                0: begin s_wr = 1; s_addr = 0; s_wdata = $urandom_range(0, 9); end
                1, 2: begin s_wr = 1; s_addr = 4; s_wdata = $urandom_range(0, 15); end
                3: begin s_wr = 1; s_addr = 5; s_wdata = $urandom_range(0, 5); end
                4: begin s_wr = 1; s_addr = 8; s_wdata = $urandom; end
                5: begin s_wr = 1; s_addr = 4'($urandom_range(0, 15)); s_wdata = $urandom; end
                default: begin s_rd = 1; s_addr = 4'($urandom_range(0, 12)); end
            endcase
            if ($urandom_range(0, 5) == 0) begin
                s_plug = 1; s_hot = 1'($urandom_range(0, 1)); s_pslot = int'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 7) == 0) begin s_unreq = 1; s_uslot = int'($urandom_range(0, 7)); end
            if ($urandom_range(0, 7) == 0) begin s_undone = 1; s_dslot = int'($urandom_range(0, 7)); end
            tick();
        end
        tick();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule